// File: doc/BRIEF.md
# Multi-Precision Row/Column Matrix Memory

This block is a small square matrix store that can be read along a row or down a column in one access. It holds a 4 x 4 grid of two-bit cells, 32 bits in all. Each cell keeps an upper sub-bit (bit 1) and a lower sub-bit (bit 0). The caller picks how those bits are grouped into matrix elements for each access. One-bit elements treat every sub-bit as its own element. Two-bit elements take one whole cell. Four-bit elements span two horizontally adjacent cells of the same row.

Writes always cover a pair of neighbouring cells in one row, four bits per clock. Reads return one complete line after one clock, with a valid flag, through a registered output. A column read of four-bit elements needs an even starting column. Any request the layout cannot serve raises an error flag and returns zero data.

Top module: `xpose_mem`

## Requirements
- R1: While reset is held and after it is released, `rd_valid`, `rd_err` and `rd_data` are 0, and every cell reads back as 0.
- R2: A write with `wr_en` high, row `wr_row` and pair `wr_pair = p` stores `wr_data[1:0]` in cell column 2p and `wr_data[3:2]` in cell column 2p+1 at one clock edge. All other cells are left unchanged.
- R3: A read request sampled at a clock edge makes `rd_valid` high after that same edge. When no request is sampled at an edge, `rd_valid` is low after it and `rd_data` keeps its value.
- R4: A row read (`rd_mode = 0`) at precision code 0 (1-bit) or code 1 (2-bit) puts cell (`rd_idx`, c) on `rd_data[2c+1:2c]`. In code 0, element j is `rd_data[j]`. Bits 15:8 are 0.
- R5: A column read (`rd_mode = 1`) at precision code 0 or 1 puts cell (r, `rd_idx`) on `rd_data[2r+1:2r]`. Bits 15:8 are 0.
- R6: A row read at precision code 2 (4-bit) returns element e as `{cell(idx,2e+1), cell(idx,2e)}` on `rd_data[4e+3:4e]`, in two consecutive two-bit lanes. Bits 15:8 are 0.
- R7: A column read at precision code 2 with an even `rd_idx = k` returns row r's element `{cell(r,k+1), cell(r,k)}` on `rd_data[4r+3:4r]`, using all 16 bits.
- R8: A column read at code 2 with an odd `rd_idx`, or any read with precision code 3, gives `rd_valid = 1`, `rd_err = 1` and `rd_data = 0`.
- R9: A read and a write to the same row in the same cycle return the data held before the write.
- R10: Mode, index and precision are taken only with the request. Changing them while no request is sampled leaves `rd_data` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_row | input | 2 | Row to write |
| wr_pair | input | 1 | Cell-pair index within the row |
| wr_data | input | 4 | Two cells of data, lower cell in bits 1:0 |
| rd_en | input | 1 | Read request |
| rd_mode | input | 1 | 0 = row read, 1 = column read |
| rd_idx | input | 2 | Row or column index |
| rd_prec | input | 2 | Element precision: 0 = 1-bit, 1 = 2-bit, 2 = 4-bit, 3 = reserved |
| rd_data | output | 16 | Registered read line |
| rd_valid | output | 1 | Read data valid |
| rd_err | output | 1 | Request could not be served |

## Verification
A write takes effect at the edge where it is sampled, so a read issued in the next cycle already sees it. Read results, the valid flag and the error flag all appear one edge after the request. The bench drives every request on a falling edge and compares the outputs on the following falling edge, half a period after the registering edge. The same-cycle read/write case and the input-hold case are each checked at that one-edge point, and again one cycle later.

// File: rtl/xpose_pkg.sv
package xpose_pkg;
    typedef enum logic [1:0] {
        PREC_1B  = 2'd0,
        PREC_2B  = 2'd1,
        PREC_4B  = 2'd2,
        PREC_BAD = 2'd3
    } prec_e;

    typedef enum logic {
        MODE_ROW = 1'b0,
        MODE_COL = 1'b1
    } mode_e;
endpackage

// File: rtl/xpose_store.sv
module xpose_store #(
    parameter int DIM    = 4,
    parameter int CELL_W = 2,
    localparam int IDX_W  = $clog2(DIM),
    localparam int PAIR_W = (DIM / 2 > 1) ? $clog2(DIM / 2) : 1,
    localparam int ARR_W  = DIM * DIM * CELL_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_row,
    input  logic [PAIR_W-1:0]     wr_pair,
    input  logic [2*CELL_W-1:0]   wr_data,
    output logic [ARR_W-1:0]      cells_q
);
    logic [ARR_W-1:0] cells_d;
    int unsigned      base;

    always_comb begin
        cells_d = cells_q;
        base    = (int'(wr_row) * DIM + 2 * int'(wr_pair)) * CELL_W;
        if (wr_en) begin
            cells_d[base +: 2*CELL_W] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cells_q <= '0;
        else        cells_q <= cells_d;
    end

    // R2: with no write the grid does not move
    p_hold_no_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cells_q));

    // R2: a write changes at most four bits
    p_write_span_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ($countones(cells_q ^ $past(cells_q)) <= 2*CELL_W));
endmodule

// File: rtl/xpose_gather.sv
module xpose_gather
    import xpose_pkg::*;
#(
    parameter int DIM    = 4,
    parameter int CELL_W = 2,
    localparam int IDX_W  = $clog2(DIM),
    localparam int ARR_W  = DIM * DIM * CELL_W,
    localparam int LINE_W = DIM * CELL_W,
    localparam int OUT_W  = 2 * LINE_W
) (
    input  logic [ARR_W-1:0] cells,
    input  logic             mode,
    input  logic [IDX_W-1:0] idx,
    input  logic [1:0]       prec,
    output logic [OUT_W-1:0] line,
    output logic             err
);
    logic [LINE_W-1:0] row_line;
    logic [LINE_W-1:0] col_line;
    logic [OUT_W-1:0]  wide_line;
    prec_e             p;
    mode_e             m;
    int unsigned       ri;
    int unsigned       pb;

    always_comb begin
        p        = prec_e'(prec);
        m        = mode_e'(mode);
        ri       = int'(idx);
        pb       = ri & ~32'd1;
        row_line = '0;
        col_line = '0;
        wide_line = '0;
        for (int c = 0; c < DIM; c++) begin
            row_line[c*CELL_W +: CELL_W] = cells[(ri*DIM + c)*CELL_W +: CELL_W];
        end
        for (int r = 0; r < DIM; r++) begin
            col_line[r*CELL_W +: CELL_W]      = cells[(r*DIM + ri)*CELL_W +: CELL_W];
            wide_line[r*2*CELL_W +: 2*CELL_W] = cells[(r*DIM + pb)*CELL_W +: 2*CELL_W];
        end
        err = (p == PREC_BAD) || (m == MODE_COL && p == PREC_4B && idx[0]);
        if (err)                              line = '0;
        else if (m == MODE_ROW)               line = {{LINE_W{1'b0}}, row_line};
        else if (p == PREC_4B)                line = wide_line;
        else                                  line = {{LINE_W{1'b0}}, col_line};
    end

    // R8: an error never carries data
    always_comb begin
        a_err_zero_r8: assert (!err || line == '0);
    end
endmodule

// File: rtl/xpose_mem.sv
module xpose_mem
    import xpose_pkg::*;
#(
    parameter int DIM    = 4,
    parameter int CELL_W = 2,
    localparam int IDX_W  = $clog2(DIM),
    localparam int PAIR_W = (DIM / 2 > 1) ? $clog2(DIM / 2) : 1,
    localparam int ARR_W  = DIM * DIM * CELL_W,
    localparam int OUT_W  = 2 * DIM * CELL_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_row,
    input  logic [PAIR_W-1:0]   wr_pair,
    input  logic [2*CELL_W-1:0] wr_data,
    input  logic                rd_en,
    input  logic                rd_mode,
    input  logic [IDX_W-1:0]    rd_idx,
    input  logic [1:0]          rd_prec,
    output logic [OUT_W-1:0]    rd_data,
    output logic                rd_valid,
    output logic                rd_err
);
    typedef struct packed {
        logic             valid;
        logic             err;
        logic [OUT_W-1:0] data;
    } rd_st_t;

    logic [ARR_W-1:0] cells_q;
    logic [OUT_W-1:0] g_line;
    logic             g_err;
    rd_st_t           rd_d, rd_q;

    xpose_store #(.DIM(DIM), .CELL_W(CELL_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_row  (wr_row),
        .wr_pair (wr_pair),
        .wr_data (wr_data),
        .cells_q (cells_q)
    );

    xpose_gather #(.DIM(DIM), .CELL_W(CELL_W)) u_gather (
        .cells (cells_q),
        .mode  (rd_mode),
        .idx   (rd_idx),
        .prec  (rd_prec),
        .line  (g_line),
        .err   (g_err)
    );

    always_comb begin
        rd_d       = rd_q;
        rd_d.valid = rd_en;
        rd_d.err   = rd_en & g_err;
        if (rd_en) rd_d.data = g_line;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rd_data  = rd_q.data;
    assign rd_valid = rd_q.valid;
    assign rd_err   = rd_q.err;

    p_valid_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (!rd_valid && $stable(rd_data)));

    p_err_shape_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_err |-> (rd_valid && rd_data == '0));

    p_odd_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_mode && rd_prec == 2'd2 && rd_idx[0]) |=> rd_err);
endmodule

// File: tb/xpose_mem_tb.sv
`timescale 1ns/1ps
module xpose_mem_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_row = '0;
    logic        wr_pair = 1'b0;
    logic [3:0]  wr_data = '0;
    logic        rd_en = 1'b0;
    logic        rd_mode = 1'b0;
    logic [1:0]  rd_idx = '0;
    logic [1:0]  rd_prec = '0;
    logic [15:0] rd_data;
    logic        rd_valid;
    logic        rd_err;

    int tests = 0;
    int fails = 0;
    logic [1:0] sh [0:3][0:3];

    always #2.5 clk = ~clk;

    xpose_mem u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_row(wr_row),
        .wr_pair(wr_pair), .wr_data(wr_data), .rd_en(rd_en),
        .rd_mode(rd_mode), .rd_idx(rd_idx), .rd_prec(rd_prec),
        .rd_data(rd_data), .rd_valid(rd_valid), .rd_err(rd_err)
    );

    // op=0 write: [6:5] row, [4] pair, [3:0] data
    // op=1 read : [6] mode, [5:4] idx, [3:2] prec
    localparam logic [7:0] SEQ [0:7] = '{
        {1'b0, 2'd0, 1'b0, 4'b1001},
        {1'b0, 2'd0, 1'b1, 4'b0110},
        {1'b0, 2'd1, 1'b0, 4'b0011},
        {1'b0, 2'd1, 1'b1, 4'b1100},
        {1'b1, 1'b0, 2'd0, 2'd1, 2'd0},
        {1'b1, 1'b0, 2'd1, 2'd1, 2'd0},
        {1'b1, 1'b1, 2'd0, 2'd1, 2'd0},
        {1'b1, 1'b1, 2'd1, 2'd1, 2'd0}
    };

    function automatic bit is_err(bit m, int idx, int p);
        return (p == 3) || (m && p == 2 && (idx % 2) == 1);
    endfunction

    function automatic logic [15:0] model(bit m, int idx, int p);
        logic [15:0] v = '0;
        if (is_err(m, idx, p)) return '0;
        for (int k = 0; k < 4; k++) begin
            if (!m)         v[2*k +: 2] = sh[idx][k];
            else if (p == 2) v[4*k +: 4] = {sh[k][idx+1], sh[k][idx]};
            else            v[2*k +: 2] = sh[k][idx];
        end
        return v;
    endfunction

    function automatic string tag_of(bit m, int idx, int p);
        if (is_err(m, idx, p)) return "R8";
        if (p == 2) return m ? "R7" : "R6";
        return m ? "R5" : "R4";
    endfunction

    task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic do_write(int row, int pair, logic [3:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_row = row[1:0]; wr_pair = pair[0]; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        sh[row][2*pair]   = d[1:0];
        sh[row][2*pair+1] = d[3:2];
    endtask

    task automatic do_read(bit m, int idx, int p, string tag);
        logic [15:0] exp;
        exp = model(m, idx, p);
        @(negedge clk);
        rd_en = 1'b1; rd_mode = m; rd_idx = idx[1:0]; rd_prec = p[1:0];
        @(negedge clk);
        rd_en = 1'b0;
        check("R3", {15'd0, rd_valid}, 16'd1);
        check(tag, {15'd0, rd_err}, {15'd0, is_err(m, idx, p)});
        check(tag, rd_data, exp);
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [15:0] held;
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 4; c++) sh[r][c] = 2'b00;

        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", {rd_valid, rd_err, 14'd0}, 16'd0);
        check("R1", rd_data, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {rd_valid, rd_err, 14'd0}, 16'd0);
        for (int r = 0; r < 4; r++) do_read(1'b0, r, 1, "R1");

        // table walk: write rows 0 and 1, read them back by row and column
        for (int i = 0; i < 8; i++) begin
            if (!SEQ[i][7]) do_write(int'(SEQ[i][6:5]), int'(SEQ[i][4]), SEQ[i][3:0]);
            else do_read(SEQ[i][6], int'(SEQ[i][5:4]), int'(SEQ[i][3:2]),
                         tag_of(SEQ[i][6], int'(SEQ[i][5:4]), int'(SEQ[i][3:2])));
        end

        // R2: a single pair write leaves the neighbour pair alone
        do_write(3, 1, 4'b1110);
        do_read(1'b0, 3, 1, "R2");
        do_write(3, 0, 4'b0001);
        do_read(1'b0, 3, 0, "R2");

        // random fills, every mode / index / precision
        for (int round = 0; round < 4; round++) begin
            for (int r = 0; r < 4; r++)
                for (int q = 0; q < 2; q++) do_write(r, q, 4'($urandom));
            for (int p = 0; p < 4; p++)
                for (int m = 0; m < 2; m++)
                    for (int k = 0; k < 4; k++)
                        do_read(m[0], k, p, tag_of(m[0], k, p));
        end

        // R9: read and write to the same row in one cycle
        do_write(2, 0, 4'b0101);
        held = model(1'b0, 2, 1);
        @(negedge clk);
        wr_en = 1'b1; wr_row = 2'd2; wr_pair = 1'b0; wr_data = 4'b1010;
        rd_en = 1'b1; rd_mode = 1'b0; rd_idx = 2'd2; rd_prec = 2'd1;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        sh[2][0] = 2'b10; sh[2][1] = 2'b10;
        check("R9", rd_data, held);
        do_read(1'b0, 2, 1, "R9");

        // R10 / R3: inputs changed with no request leave the output alone
        do_read(1'b1, 2, 2, "R10");
        held = model(1'b1, 2, 2);
        rd_mode = 1'b0; rd_idx = 2'd1; rd_prec = 2'd3;
        @(negedge clk);
        check("R10", rd_data, held);
        check("R3", {15'd0, rd_valid}, 16'd0);
        @(negedge clk);
        check("R10", rd_data, held);

        // R8: reserved precision, odd 4-bit column
        do_read(1'b0, 0, 3, "R8");
        do_read(1'b1, 3, 2, "R8");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule